// File: doc/BRIEF.md
# UART Automatic Power-Down Controller

This block decides, for each of several UART channels, when the transmit half and the receive half may drop into a low-power state and when they must come back. Each half has its own idle condition and its own wake event, so one half can sleep while the other is still working. The transmitter sleeps once nothing is waiting to be sent. The receiver sleeps once nothing is waiting to be read and no character is arriving. A host write to the transmit buffer wakes the transmitter. Any level change on the serial input wakes the receiver.

A software bit per channel forces both halves down whatever the automatic logic decides. A second bit per channel turns the automatic behaviour on. The ring-indicator input is watched all the time, and every change on it raises a one-cycle interrupt request, whether or not the channel is powered down. Both asynchronous pins pass through a two-flop synchronizer before their edges are detected. The UART datapath, the baud clock and the clock gating that acts on the outputs are outside this block.

Top module: `uart_pm_ctrl`

## Requirements
- R1: While `pd_force[c]` is 1, `tx_pd[c]` and `rx_pd[c]` are 1 in that same cycle, whatever `apm_en[c]` is.
- R2: While `apm_en[c]` is 0 and `pd_force[c]` is 0, `tx_pd[c]` and `rx_pd[c]` stay 0, even when every idle flag is 1.
- R3: With `apm_en[c]` at 1, `tx_pd[c]` rises at the first clock edge at which `thr_empty[c]` and `tsr_empty[c]` are both 1. It does not rise while only one of the two flags is 1.
- R4: With `apm_en[c]` at 1, `rx_pd[c]` rises at the first clock edge at which `rxf_empty[c]` and `rx_hunt[c]` are both 1. It does not rise while only one of the two flags is 1.
- R5: A 1 on `thr_wr[c]` clears the transmit sleep state at the next clock edge. If a write arrives in the same cycle as the idle condition first holds, the write wins and `tx_pd[c]` stays 0 for that edge.
- R6: A level change on `rxd[c]` clears the receive sleep state at the third clock edge after the change, because two edges are spent in synchronization and one in the state register.
- R7: Each level change on `ri[c]` makes `ri_irq[c]` 1 for exactly one cycle, in the cycle after the second clock edge that follows the change. This also happens while the channel is powered down.
- R8: When `apm_en[c]` goes to 0, the automatic part of `tx_pd[c]` and `rx_pd[c]` drops in that same cycle. The sleep state is cleared at the next edge, so setting the bit again does not bring back the old power-down.
- R9: The channels are independent. The inputs of one channel never change the outputs of another.
- R10: While reset is asserted, `tx_pd`, `rx_pd` and `ri_irq` are 0 for every channel whose `pd_force` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_force | input | NCH | Per channel: forces both halves into power-down |
| apm_en | input | NCH | Per channel: enables automatic power management |
| thr_empty | input | NCH | Per channel: transmit holding buffer is empty |
| tsr_empty | input | NCH | Per channel: transmit shift register is empty |
| rxf_empty | input | NCH | Per channel: receive FIFO is empty |
| rx_hunt | input | NCH | Per channel: receiver is idle, waiting for a start bit |
| thr_wr | input | NCH | Per channel: host write strobe to the transmit buffer |
| rxd | input | NCH | Per channel: asynchronous serial receive pin |
| ri | input | NCH | Per channel: asynchronous ring-indicator pin |
| tx_pd | output | NCH | Per channel: transmitter power-down |
| rx_pd | output | NCH | Per channel: receiver power-down |
| ri_irq | output | NCH | Per channel: one-cycle pulse on each ring-indicator change |

## Verification
Each result has its own latency, and every check samples at that cycle. The force and enable-clear effects are combinational, so they are checked in the same cycle as the stimulus, before the next edge. Transmit entry, receive entry and the write wake are due one edge after the stimulus. A change on the serial input wakes the receiver at the third edge, and a ring-indicator change shows on the interrupt after the second edge. The bench drives inputs just after a rising edge and samples on the falling edge. For each registered result it also checks the cycle before the result is due, so a result that comes a cycle early or late is caught.

// File: rtl/uart_pm_ctrl.sv
module uart_pm_ctrl #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pd_force,
  input  logic [NCH-1:0] apm_en,
  input  logic [NCH-1:0] thr_empty,
  input  logic [NCH-1:0] tsr_empty,
  input  logic [NCH-1:0] rxf_empty,
  input  logic [NCH-1:0] rx_hunt,
  input  logic [NCH-1:0] thr_wr,
  input  logic [NCH-1:0] rxd,
  input  logic [NCH-1:0] ri,
  output logic [NCH-1:0] tx_pd,
  output logic [NCH-1:0] rx_pd,
  output logic [NCH-1:0] ri_irq
);

  localparam int SYNC_W = 3;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SYNC_W-1:0] rxd_q, ri_q;
    logic tx_sleep, rx_sleep, rxd_edge;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxd_q <= '1;
        ri_q  <= '1;
      end else begin
        rxd_q <= {rxd_q[SYNC_W-2:0], rxd[c]};
        ri_q  <= {ri_q[SYNC_W-2:0], ri[c]};
      end
    end

    assign rxd_edge = rxd_q[SYNC_W-1] ^ rxd_q[SYNC_W-2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tx_sleep <= 1'b0;
      else if (!apm_en[c] || thr_wr[c]) tx_sleep <= 1'b0;
      else if (thr_empty[c] && tsr_empty[c]) tx_sleep <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rx_sleep <= 1'b0;
      else if (!apm_en[c] || rxd_edge) rx_sleep <= 1'b0;
      else if (rxf_empty[c] && rx_hunt[c]) rx_sleep <= 1'b1;
    end

    assign tx_pd[c]  = pd_force[c] | (apm_en[c] & tx_sleep);
    assign rx_pd[c]  = pd_force[c] | (apm_en[c] & rx_sleep);
    assign ri_irq[c] = ri_q[SYNC_W-1] ^ ri_q[SYNC_W-2];
  end

endmodule

// File: rtl/uart_pm_ctrl_chk.sv
module uart_pm_ctrl_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pd_force,
  input logic [NCH-1:0] apm_en,
  input logic [NCH-1:0] thr_empty,
  input logic [NCH-1:0] tsr_empty,
  input logic [NCH-1:0] rxf_empty,
  input logic [NCH-1:0] rx_hunt,
  input logic [NCH-1:0] thr_wr,
  input logic [NCH-1:0] tx_pd,
  input logic [NCH-1:0] rx_pd
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_force_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pd_force[c] |-> (tx_pd[c] && rx_pd[c]));

    assert_auto_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!apm_en[c] && !pd_force[c]) |-> (!tx_pd[c] && !rx_pd[c]));

    assert_tx_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_en[c] && thr_empty[c] && tsr_empty[c] && !thr_wr[c]) ##1 apm_en[c] |-> tx_pd[c]);

    assert_rx_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_pd[c]) && !pd_force[c]) |-> $past(rxf_empty[c] && rx_hunt[c]));

    assert_tx_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr[c] && !pd_force[c]) |=> (!tx_pd[c] || pd_force[c]));
  end

endmodule

bind uart_pm_ctrl uart_pm_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_force(pd_force), .apm_en(apm_en),
  .thr_empty(thr_empty), .tsr_empty(tsr_empty), .rxf_empty(rxf_empty),
  .rx_hunt(rx_hunt), .thr_wr(thr_wr), .tx_pd(tx_pd), .rx_pd(rx_pd)
);

// File: tb/sim_uart_pm_ctrl.sv
`timescale 1ns/1ps
module sim_uart_pm_ctrl;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] pd_force, apm_en, thr_empty, tsr_empty, rxf_empty, rx_hunt, thr_wr, rxd, ri;
  logic [NCH-1:0] tx_pd, rx_pd, ri_irq;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  uart_pm_ctrl #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_force(pd_force), .apm_en(apm_en),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .rxf_empty(rxf_empty),
    .rx_hunt(rx_hunt), .thr_wr(thr_wr), .rxd(rxd), .ri(ri),
    .tx_pd(tx_pd), .rx_pd(rx_pd), .ri_irq(ri_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic samp();
    @(negedge clk);
  endtask

  task automatic defaults();
    pd_force = '0; apm_en = '0; thr_empty = '0; tsr_empty = '0;
    rxf_empty = '0; rx_hunt = '0; thr_wr = '0; rxd = '1; ri = '1;
  endtask

  task automatic settle();
    defaults();
    repeat (5) step();
  endtask

  task automatic t_reset();
    defaults();
    rst_n = 1'b0;
    thr_empty = '1; tsr_empty = '1; rxf_empty = '1; rx_hunt = '1; apm_en = '1;
    repeat (3) @(posedge clk);
    samp();
    chk("R10 tx_pd in reset", 8'(tx_pd), 8'(0));
    chk("R10 rx_pd in reset", 8'(rx_pd), 8'(0));
    chk("R10 ri_irq in reset", 8'(ri_irq), 8'(0));
    step();
    defaults();
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_force();
    pd_force = 2'b01;
    #1;
    chk("R1 force tx", 8'(tx_pd), 8'(2'b01));
    chk("R1 force rx", 8'(rx_pd), 8'(2'b01));
    apm_en = 2'b11;
    #1;
    chk("R1 force with auto on", 8'({tx_pd, rx_pd}), 8'(4'b0101));
    settle();
  endtask

  task automatic t_disabled();
    thr_empty = '1; tsr_empty = '1; rxf_empty = '1; rx_hunt = '1;
    repeat (3) step();
    samp();
    chk("R2 no auto pd when disabled", 8'({tx_pd, rx_pd}), 8'(0));
    settle();
  endtask

  task automatic t_tx_entry();
    apm_en = 2'b11; thr_empty = 2'b11; tsr_empty = 2'b01;
    samp();
    chk("R3 tx_pd not before edge", 8'(tx_pd), 8'(0));
    step(); samp();
    chk("R3/R9 tx entry needs both flags", 8'(tx_pd), 8'(2'b01));
    chk("R9 rx unaffected by tx idle", 8'(rx_pd), 8'(0));
    tsr_empty = 2'b11;
    step(); samp();
    chk("R3 tx entry ch1", 8'(tx_pd), 8'(2'b11));
    settle();
  endtask

  task automatic t_tx_wake();
    apm_en = 2'b01; thr_empty = 2'b01; tsr_empty = 2'b01;
    step(); samp();
    chk("R3 tx asleep", 8'(tx_pd), 8'(2'b01));
    step();
    thr_wr = 2'b01; thr_empty = 2'b00;
    samp();
    chk("R5 tx_pd held until edge", 8'(tx_pd), 8'(2'b01));
    step();
    thr_wr = 2'b00;
    samp();
    chk("R5 tx woken by write", 8'(tx_pd), 8'(0));
    thr_empty = 2'b01;
    step(); samp();
    chk("R3 tx re-enters after drain", 8'(tx_pd), 8'(2'b01));
    settle();
  endtask

  task automatic t_same_cycle();
    apm_en = 2'b01; thr_empty = 2'b01; tsr_empty = 2'b01; thr_wr = 2'b01;
    step();
    thr_wr = 2'b00;
    samp();
    chk("R5 same-cycle write wins", 8'(tx_pd), 8'(0));
    step(); samp();
    chk("R5 entry one edge later", 8'(tx_pd), 8'(2'b01));
    settle();
  endtask

  task automatic t_rx_entry();
    apm_en = 2'b11; rxf_empty = 2'b11; rx_hunt = 2'b10;
    samp();
    chk("R4 rx_pd not before edge", 8'(rx_pd), 8'(0));
    step(); samp();
    chk("R4 rx entry needs both flags", 8'(rx_pd), 8'(2'b10));
    chk("R9 tx unaffected by rx idle", 8'(tx_pd), 8'(0));
    settle();
  endtask

  task automatic t_rx_wake();
    apm_en = 2'b11; rxf_empty = 2'b11; rx_hunt = 2'b11;
    step(); samp();
    chk("R4 both rx asleep", 8'(rx_pd), 8'(2'b11));
    step();
    rxd[0] = 1'b0;
    step(); step(); samp();
    chk("R6 rx still asleep after two edges", 8'(rx_pd), 8'(2'b11));
    step(); samp();
    chk("R6/R9 rx ch0 woken at third edge", 8'(rx_pd), 8'(2'b10));
    step(); samp();
    chk("R4 rx re-enters while idle", 8'(rx_pd), 8'(2'b11));
    settle();
  endtask

  task automatic t_ri();
    pd_force = 2'b10;
    step();
    ri[1] = 1'b0;
    step(); samp();
    chk("R7 no irq after one edge", 8'(ri_irq), 8'(0));
    step(); samp();
    chk("R7 irq while powered down", 8'(ri_irq), 8'(2'b10));
    step(); samp();
    chk("R7 irq lasts one cycle", 8'(ri_irq), 8'(0));
    ri[1] = 1'b1;
    step(); step(); samp();
    chk("R7 irq on rising change", 8'(ri_irq), 8'(2'b10));
    settle();
  endtask

  task automatic t_en_clear();
    apm_en = 2'b01; thr_empty = 2'b01; tsr_empty = 2'b01; rxf_empty = 2'b01; rx_hunt = 2'b01;
    step(); samp();
    chk("R3/R4 both halves asleep", 8'({tx_pd, rx_pd}), 8'(4'b0101));
    step();
    apm_en = 2'b00;
    #1;
    chk("R8 clear drops pd at once", 8'({tx_pd, rx_pd}), 8'(0));
    step();
    apm_en = 2'b01;
    #1;
    chk("R8 sleep state cleared", 8'({tx_pd, rx_pd}), 8'(0));
    settle();
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    defaults();
    t_reset();
    t_force();
    t_disabled();
    t_tx_entry();
    t_tx_wake();
    t_same_cycle();
    t_rx_entry();
    t_rx_wake();
    t_ri();
    t_en_clear();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule